// File: doc/BRIEF.md
# Binary Tick Counter with Per-Tap Interrupts

This peripheral divides a 256 Hz tick into an 8-bit binary count. Counter bit 0 toggles at 128 Hz and bit 7 toggles at 1 Hz. The tick is a one-cycle enable pulse in the system clock domain. The count advances on a tick only while both the clock-enable bit and the run bit are set. Software can clear the count at any time with a self-clearing reset bit.

Each of the eight counter bits has its own event flag. A flag is raised whenever its bit falls from 1 to 0 during counting, whether or not its mask bit allows it. A flag stays set until software writes a one to it. The single interrupt request output is high while any flag is set together with its mask-enable bit.

Registers are 4 bits wide and are reached over a small bus with a 3-bit offset and separate read and write strobes. Read data is combinational from the offset. Writes take effect at the clock edge on which the write strobe is high.

Top module: `binclk_timer`

## Requirements
- R1: After reset, the counter, the enable bit, the run bit, all mask bits and all flag bits are 0, and `irq` is low.
- R2: On a clock edge where `tick_256` is high and both the enable bit and the run bit are 1, the count increases by one and wraps from 255 to 0. In every other case the count holds.
- R3: Offset 0 holds the enable bit in bit 0. It is readable and writable, and bits 3:1 read as 0.
- R4: Offset 1 holds the run bit in bit 0 (1 = run) and the counter reset bit in bit 1. Bits 3:1 always read as 0.
- R5: Writing 1 to bit 1 at offset 1 sets the count to 0 at that edge, even if a counting tick arrives in the same cycle. Writing 0 to that bit leaves the count unchanged.
- R6: Offset 2 reads count bits 3:0 (the 128 Hz tap in bit 0), and offset 3 reads count bits 7:4 (the 1 Hz tap in bit 3). Writes to these offsets are ignored.
- R7: Offset 4 holds the mask bits for taps 3:0 and offset 5 holds those for taps 7:4. The bits are readable and writable, and 1 enables the tap.
- R8: A flag is set on the edge where a tick makes its counter bit go from 1 to 0, regardless of its mask. Offset 6 reads flags 3:0 and offset 7 reads flags 7:4. Clearing the count with the reset bit sets no flag.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set event and a clear write hit the same flag in one cycle, the flag ends up set.
- R10: `irq` is the OR over the eight taps of flag AND mask.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_256 | input | 1 | One-cycle 256 Hz advance pulse |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 4 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
A write or a tick that is present at a clock edge changes the registers at that edge. A read of the same offset returns the new value in the next cycle, because read data is combinational from the registers. `irq` follows a flag or mask change in the cycle after the edge that caused it. The bench drives every stimulus on the falling edge and holds it across exactly one rising edge. It samples read data and `irq` one nanosecond after the next falling edge, so each result is seen exactly one register stage after its cause. The same-cycle cases (reset against a tick, clear against a set) are driven as one combined bus cycle.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_ENA   = 3'd0,
    OFS_CTRL  = 3'd1,
    OFS_CNTLO = 3'd2,
    OFS_CNTHI = 3'd3,
    OFS_MSKLO = 3'd4,
    OFS_MSKHI = 3'd5,
    OFS_FLGLO = 3'd6,
    OFS_FLGHI = 3'd7
  } ofs_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT = 1;
endpackage

// File: rtl/bct_rst_sync.sv
module bct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bct_counter.sv
module bct_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = adv_i | clr_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // bit i drops to 0 on an increment exactly when bits i..0 are all ones
  for (genvar i = 0; i < W; i++) begin : g_fall
    assign fall_o[i] = adv_i & ~clr_i & (&cnt_q[i:0]);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bct_flags.sv
module bct_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d, flag_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      flag_en[i] = set_i[i] | clr_i[i];
      flag_d[i]  = set_i[i];   // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bct_ctrl.sv
module bct_ctrl
  import bct_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  input  logic              wr_i,
  output logic              ck_en_o,
  output logic              run_o,
  output logic              cnt_clr_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      flag_w1c_o
);
  localparam int unsigned NNIB = W / NIB_W;

  logic         ck_en_q, run_q, ctl_we, ena_we;
  logic [W-1:0] mask_q, mask_d;
  logic [NNIB-1:0] msk_we, flg_we;

  always_comb begin
    ena_we    = wr_i && (addr_i == OFS_ENA);
    ctl_we    = wr_i && (addr_i == OFS_CTRL);
    cnt_clr_o = ctl_we && wdata_i[CTRL_CLR_BIT];
    mask_d    = mask_q;
    for (int n = 0; n < NNIB; n++) begin
      msk_we[n] = wr_i && (addr_i == ADDR_W'(OFS_MSKLO + n));
      flg_we[n] = wr_i && (addr_i == ADDR_W'(OFS_FLGLO + n));
      if (msk_we[n]) mask_d[n*NIB_W +: NIB_W] = wdata_i;
      flag_w1c_o[n*NIB_W +: NIB_W] = flg_we[n] ? wdata_i : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ck_en_q <= 1'b0;
    else if (ena_we) ck_en_q <= wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (ctl_we) run_q <= wdata_i[CTRL_RUN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (|msk_we)   mask_q <= mask_d;
  end

  assign ck_en_o = ck_en_q;
  assign run_o   = run_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/binclk_timer.sv
module binclk_timer
  import bct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_256,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [NIB_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             rst_sync_n;
  logic             ck_en, run, clr_cnt, adv;
  logic [CNT_W-1:0] cnt, fall, mask, flag, w1c;
  logic [NIB_W-1:0] rmux;

  bct_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bct_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .wr_i(bus_wr), .ck_en_o(ck_en), .run_o(run), .cnt_clr_o(clr_cnt),
    .mask_o(mask), .flag_w1c_o(w1c)
  );

  assign adv = tick_256 & ck_en & run;

  bct_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .adv_i(adv), .clr_i(clr_cnt),
    .cnt_o(cnt), .fall_o(fall)
  );

  bct_flags #(.W(CNT_W)) u_flg (
    .clk(clk), .rst_n(rst_sync_n), .set_i(fall), .clr_i(w1c), .flag_o(flag)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_ENA:   rmux = {3'b000, ck_en};
      OFS_CTRL:  rmux = {3'b000, run};
      OFS_CNTLO: rmux = cnt[3:0];
      OFS_CNTHI: rmux = cnt[7:4];
      OFS_MSKLO: rmux = mask[3:0];
      OFS_MSKHI: rmux = mask[7:4];
      OFS_FLGLO: rmux = flag[3:0];
      default:   rmux = flag[7:4];
    endcase
    bus_rdata = bus_rd ? rmux : '0;
    irq       = |(flag & mask);
  end
endmodule

// File: rtl/bct_checker.sv
module bct_checker (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       tick_256,
  input logic [2:0] bus_addr,
  input logic [3:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [3:0] bus_rdata,
  input logic       irq,
  input logic       ck_en,
  input logic       run,
  input logic [7:0] cnt,
  input logic [7:0] mask,
  input logic [7:0] flag
);
  logic       go, wipe;
  logic [7:0] kill;

  always_comb begin
    go   = tick_256 && ck_en && run;
    wipe = bus_wr && bus_addr == 3'd1 && bus_wdata[1];
    kill = {(bus_wr && bus_addr == 3'd7) ? bus_wdata : 4'h0,
            (bus_wr && bus_addr == 3'd6) ? bus_wdata : 4'h0};
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!go && !wipe) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && !wipe) |=> cnt == 8'($past(cnt) + 8'd1));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wipe |=> cnt == 8'd0);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && !wipe && cnt == 8'hFF) |=> flag == 8'hFF);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((flag & $past(flag & ~kill)) == $past(flag & ~kill)));

  p_nomask_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask == 8'h00) |-> !irq);

  p_rdidle_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |-> bus_rdata == 4'h0);
endmodule

bind binclk_timer bct_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .tick_256(tick_256),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq), .ck_en(ck_en),
  .run(run), .cnt(cnt), .mask(mask), .flag(flag)
);

// File: tb/binclk_timer_test.sv
`timescale 1ns/1ps
module binclk_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_256;
  logic [2:0] bus_addr;
  logic [3:0] bus_wdata;
  logic       bus_wr, bus_rd;
  logic [3:0] bus_rdata;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  binclk_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus/tick cycle held across a single rising edge
  task automatic cyc(input logic tk, input logic wr, input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    tick_256 = tk; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 tick_256 = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 3'd0, 4'h0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [3:0] exp);
    logic [3:0] d;
    rd(a, d);
    chk(req, {4'h0, d}, {4'h0, exp});
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 4'h0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_enable_reg;
    wr(3'd0, 4'hF);
    rd_chk("R3 set", 3'd0, 4'h1);
    wr(3'd0, 4'hE);
    rd_chk("R3 clear", 3'd0, 4'h0);
  endtask

  task automatic t_ctrl_reg;
    wr(3'd1, 4'hF);
    rd_chk("R4 run+clr read", 3'd1, 4'h1);
    wr(3'd1, 4'h0);
    rd_chk("R4 stop", 3'd1, 4'h0);
  endtask

  task automatic t_count;
    wr(3'd0, 4'h1); wr(3'd1, 4'h1);
    ticks(5);
    rd_chk("R2 five ticks lo", 3'd2, 4'h5);
    rd_chk("R6 hi", 3'd3, 4'h0);
    wr(3'd1, 4'h0); ticks(3);
    rd_chk("R2 stopped", 3'd2, 4'h5);
    wr(3'd1, 4'h1); wr(3'd0, 4'h0); ticks(3);
    rd_chk("R2 disabled", 3'd2, 4'h5);
    wr(3'd0, 4'h1);
    ticks(14);
    rd_chk("R6 lo 0x13", 3'd2, 4'h3);
    rd_chk("R6 hi 0x13", 3'd3, 4'h1);
    wr(3'd2, 4'hA); wr(3'd3, 4'hA);
    rd_chk("R6 write ignored lo", 3'd2, 4'h3);
    rd_chk("R6 write ignored hi", 3'd3, 4'h1);
  endtask

  task automatic t_reset_bit;
    wr(3'd1, 4'h1);   // reset bit 0: no effect
    rd_chk("R5 zero write", 3'd2, 4'h3);
    cyc(1'b1, 1'b1, 3'd1, 4'h3);   // clear with tick in same cycle
    rd_chk("R5 clear wins lo", 3'd2, 4'h0);
    rd_chk("R5 clear wins hi", 3'd3, 4'h0);
    rd_chk("R4 run kept", 3'd1, 4'h1);
  endtask

  task automatic t_flags_irq;
    wr(3'd6, 4'hF); wr(3'd7, 4'hF);
    rd_chk("R8 no flag from clear", 3'd6, 4'h0);
    ticks(1);
    rd_chk("R8 no fall yet", 3'd6, 4'h0);
    ticks(1);
    rd_chk("R8 bit0 fell", 3'd6, 4'h1);
    chk("R10 masked", {7'd0, irq}, 8'd0);
    wr(3'd4, 4'h1);
    rd_chk("R7 mask lo", 3'd4, 4'h1);
    chk("R10 unmasked", {7'd0, irq}, 8'd1);
    wr(3'd6, 4'h0);
    rd_chk("R9 write0 keeps", 3'd6, 4'h1);
    wr(3'd6, 4'h1);
    rd_chk("R9 write1 clears", 3'd6, 4'h0);
    chk("R10 cleared", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_race;
    // count 2 -> 3 sets nothing; 3 -> 4 drops bits 0 and 1
    ticks(1);
    wr(3'd6, 4'hF);
    cyc(1'b1, 1'b1, 3'd6, 4'h3);
    rd_chk("R9 set beats clear", 3'd6, 4'h3);
    wr(3'd6, 4'h1);
    rd_chk("R9 partial clear", 3'd6, 4'h2);
  endtask

  task automatic t_wrap;
    wr(3'd1, 4'h3);
    ticks(255);
    rd_chk("R2 at 255 hi", 3'd3, 4'hF);
    wr(3'd6, 4'hF); wr(3'd7, 4'hF);
    wr(3'd4, 4'h0); wr(3'd5, 4'h8);
    rd_chk("R7 mask hi", 3'd5, 4'h8);
    chk("R10 none", {7'd0, irq}, 8'd0);
    ticks(1);
    rd_chk("R2 wrap lo", 3'd2, 4'h0);
    rd_chk("R8 all lo", 3'd6, 4'hF);
    rd_chk("R8 all hi", 3'd7, 4'hF);
    chk("R10 1Hz tap", {7'd0, irq}, 8'd1);
    @(negedge clk); bus_addr = 3'd7; #1;
    chk("R11 idle read zero", {4'h0, bus_rdata}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; tick_256 = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = 3'd0; bus_wdata = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset;
    t_enable_reg;
    t_ctrl_reg;
    t_count;
    t_reset_bit;
    t_flags_irq;
    t_race;
    t_wrap;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule